// File: doc/BRIEF.md
# Lane Alignment Sequence Generator

This block produces the alignment preamble that a converter link transmitter sends on a lane, between code group synchronization and user data. It keeps a local multiframe counter that advances one octet per clock over a multiframe of F×K octets. A single-cycle SYSREF pulse clears the counter, so every device sharing that pulse counts in step within one clock.

While the receiver holds SYNC~ low, the block emits the comma character /K/. Once SYNC~ is high, the block waits for the counter's next return to zero. It then sends four multiframes back to back. Each multiframe opens with /R/ and closes with /A/. The second multiframe also carries /Q/ and fourteen configuration octets, which are taken from an input bus. A strobe marks the final octet, and from the next octet on the output belongs to the data phase, shown here as zero octets. The sequence is always sent without scrambling. Encoding to 10-bit symbols happens downstream.

Top module: `ilas_gen`

## Requirements
- R1: The multiframe counter starts at 0 after reset and advances by one per clock. After reaching F×K−1 it returns to 0. F and K are supplied minus one on `f_m1` and `k_m1`, and F×K must be at least 17.
- R2: When `sysref` is high in a cycle, the counter is 0 in the following cycle.
- R3: During reset, and while waiting, the output is 0xBC with `oct_k`=1. The sequence's first octet appears in the first cycle after SYNC~ has been sampled high in which the counter is 0.
- R4: The sequence lasts exactly 4×F×K consecutive octets with no gap. After it ends, every following octet is 0x00 with `oct_k`=0 until SYNC~ falls.
- R5: In multiframes 1, 3 and 4, counter position 0 carries 0x1C with `oct_k`=1 and position F×K−1 carries 0x7C with `oct_k`=1. Every other position p carries the low 8 bits of p with `oct_k`=0.
- R6: Multiframe 2 has the same first and last octet as the others. Position 1 carries 0x9C with `oct_k`=1. Positions 2 to 15 carry configuration octet i=p−2, taken from `cfg_oct[8i+7:8i]`, with `oct_k`=0. The remaining positions carry the ramp of R5.
- R7: `ilas_done` is 1 only in the cycle of the last octet of multiframe 4.
- R8: If SYNC~ is sampled low, the next cycle's output is 0xBC with `oct_k`=1, whether the block was in the sequence or in the data phase. A later rise of SYNC~ starts a fresh sequence at the next counter zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sysref | input | 1 | Counter alignment pulse |
| sync_n | input | 1 | Receiver synchronization request, low = request |
| f_m1 | input | FW | Octets per frame minus one |
| k_m1 | input | KW | Frames per multiframe minus one |
| cfg_oct | input | 8×CFG_N | Configuration octets, octet 0 in the low bits |
| oct_data | output | 8 | Output octet |
| oct_k | output | 1 | Octet is a control character |
| ilas_done | output | 1 | Last octet of the sequence |

## Verification
The bench keeps the default widths (FW=8, KW=5, CFG_N=14). It runs several multiframe geometries: F=1 with K=17, the shortest multiframe that fits the configuration octets, plus F=4/K=5, F=2/K=16 and F=8/K=4. This exposes both the edge where the last configuration octet sits right before /A/ and multiframes where the frame size plays no role. Each geometry is run with a different SYNC~ release timing. One case releases SYNC~ on the very cycle the counter is at its last position, one releases it at once, and one puts a SYSREF pulse before the release to move the boundary. Directed runs drop SYNC~ both during the sequence and during the data phase.

// File: rtl/ilas_pkg.sv
package ilas_pkg;
   localparam logic [7:0] OCT_R = 8'h1C;  // K28.0
   localparam logic [7:0] OCT_A = 8'h7C;  // K28.3
   localparam logic [7:0] OCT_Q = 8'h9C;  // K28.4
   localparam logic [7:0] OCT_K = 8'hBC;  // K28.5
   localparam logic [7:0] OCT_IDLE = 8'h00;

   typedef enum logic [1:0] {
      PH_CGS  = 2'd0,
      PH_ILAS = 2'd1,
      PH_DATA = 2'd2
   } ilas_phase_e;
endpackage

// File: rtl/ilas_lmfc.sv
module ilas_lmfc #(
   parameter int FW = 8,
   parameter int KW = 5,
   localparam int LW = FW + KW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sysref,
   input  logic [FW-1:0] f_m1,
   input  logic [KW-1:0] k_m1,
   output logic [LW-1:0] cnt,
   output logic          at_last,
   output logic          wrap_next
);
   logic [LW:0]   mf_len;
   logic [LW-1:0] last_pos;

   always_comb begin
      mf_len   = ((LW+1)'(f_m1) + 1'b1) * ((LW+1)'(k_m1) + 1'b1);
      last_pos = LW'(mf_len - 1'b1);
   end

   assign at_last   = (cnt == last_pos);
   assign wrap_next = at_last || sysref;

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt <= '0;
      else if (wrap_next) cnt <= '0;
      else                cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ilas_fsm.sv
module ilas_fsm
   import ilas_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sync_n,
   input  logic        at_last,
   input  logic        wrap_next,
   output ilas_phase_e phase,
   output logic [1:0]  mf_idx,
   output logic        done
);
   assign done = (phase == PH_ILAS) && (mf_idx == 2'd3) && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= PH_CGS;
         mf_idx <= 2'd0;
      end else if (!sync_n) begin
         phase  <= PH_CGS;
         mf_idx <= 2'd0;
      end else begin
         case (phase)
            PH_CGS: if (wrap_next) phase <= PH_ILAS;
            PH_ILAS: if (at_last) begin
               if (mf_idx == 2'd3) phase <= PH_DATA;
               mf_idx <= mf_idx + 2'd1;
            end
            default: phase <= PH_DATA;
         endcase
      end
   end
endmodule

// File: rtl/ilas_octet_mux.sv
module ilas_octet_mux
   import ilas_pkg::*;
#(
   parameter int LW    = 13,
   parameter int CFG_N = 14,
   localparam int CI_W = $clog2(CFG_N),
   localparam int CI_N = 2 ** CI_W
) (
   input  ilas_phase_e        phase,
   input  logic [1:0]         mf_idx,
   input  logic [LW-1:0]      cnt,
   input  logic               at_last,
   input  logic [CFG_N*8-1:0] cfg_oct,
   output logic [7:0]         oct_data,
   output logic               oct_k
);
   logic [7:0]    cfg_arr [CI_N];
   logic [LW-1:0] cidx;
   logic          in_cfg;

   for (genvar i = 0; i < CI_N; i++) begin : g_cfg
      if (i < CFG_N) begin : g_used
         assign cfg_arr[i] = cfg_oct[8*i +: 8];
      end else begin : g_pad
         assign cfg_arr[i] = 8'h00;
      end
   end

   assign cidx   = cnt - LW'(2);
   assign in_cfg = (cnt >= LW'(2)) && (cnt < LW'(CFG_N + 2));

   always_comb begin
      oct_data = OCT_IDLE;
      oct_k    = 1'b0;
      case (phase)
         PH_CGS: begin
            oct_data = OCT_K;
            oct_k    = 1'b1;
         end
         PH_ILAS: begin
            if (cnt == '0) begin
               oct_data = OCT_R;
               oct_k    = 1'b1;
            end else if (at_last) begin
               oct_data = OCT_A;
               oct_k    = 1'b1;
            end else if (mf_idx == 2'd1 && cnt == LW'(1)) begin
               oct_data = OCT_Q;
               oct_k    = 1'b1;
            end else if (mf_idx == 2'd1 && in_cfg) begin
               oct_data = cfg_arr[cidx[CI_W-1:0]];
            end else begin
               oct_data = cnt[7:0];
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ilas_gen.sv
module ilas_gen
   import ilas_pkg::*;
#(
   parameter int FW    = 8,
   parameter int KW    = 5,
   parameter int CFG_N = 14,
   localparam int LW   = FW + KW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sysref,
   input  logic               sync_n,
   input  logic [FW-1:0]      f_m1,
   input  logic [KW-1:0]      k_m1,
   input  logic [CFG_N*8-1:0] cfg_oct,
   output logic [7:0]         oct_data,
   output logic               oct_k,
   output logic               ilas_done
);
   if (FW < 1 || KW < 1 || LW < 8) begin : g_bad_width
      $error("ilas_gen: FW and KW must be positive with FW+KW >= 8");
   end
   if (CFG_N < 2 || CFG_N + 2 >= 2 ** LW) begin : g_bad_cfg
      $error("ilas_gen: CFG_N does not fit a multiframe");
   end

   logic [LW-1:0] lmfc_cnt;
   logic          lmfc_last;
   logic          lmfc_wrap;
   ilas_phase_e   phase;
   logic [1:0]    mf_idx;

   ilas_lmfc #(.FW(FW), .KW(KW)) u_lmfc (
      .clk       (clk),
      .rst_n     (rst_n),
      .sysref    (sysref),
      .f_m1      (f_m1),
      .k_m1      (k_m1),
      .cnt       (lmfc_cnt),
      .at_last   (lmfc_last),
      .wrap_next (lmfc_wrap)
   );

   ilas_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_n    (sync_n),
      .at_last   (lmfc_last),
      .wrap_next (lmfc_wrap),
      .phase     (phase),
      .mf_idx    (mf_idx),
      .done      (ilas_done)
   );

   ilas_octet_mux #(.LW(LW), .CFG_N(CFG_N)) u_mux (
      .phase    (phase),
      .mf_idx   (mf_idx),
      .cnt      (lmfc_cnt),
      .at_last  (lmfc_last),
      .cfg_oct  (cfg_oct),
      .oct_data (oct_data),
      .oct_k    (oct_k)
   );
endmodule

// File: rtl/ilas_gen_chk.sv
module ilas_gen_chk
   import ilas_pkg::*;
#(
   parameter int LW = 13
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sysref,
   input logic          sync_n,
   input logic [LW-1:0] cnt,
   input logic          at_last,
   input ilas_phase_e   phase,
   input logic [7:0]    oct_data,
   input logic          oct_k,
   input logic          ilas_done
);
   // R1
   lmfc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_last && !sysref |=> cnt == '0);
   // R1
   lmfc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !at_last && !sysref |=> cnt == $past(cnt) + 1'b1);
   // R2
   sysref_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sysref |=> cnt == '0);
   // R3
   start_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phase == PH_ILAS) |-> cnt == '0);
   // R3
   wait_comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_CGS |-> oct_data == OCT_K && oct_k);
   // R5
   marker_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_ILAS && oct_k |->
         (oct_data == OCT_R || oct_data == OCT_A || oct_data == OCT_Q));
   // R7
   done_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ilas_done && sync_n |=> phase == PH_DATA && oct_data == OCT_IDLE && !oct_k);
   // R8
   sync_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_n |=> oct_data == OCT_K && oct_k && !ilas_done);
endmodule

bind ilas_gen ilas_gen_chk #(.LW(LW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sysref    (sysref),
   .sync_n    (sync_n),
   .cnt       (lmfc_cnt),
   .at_last   (lmfc_last),
   .phase     (phase),
   .oct_data  (oct_data),
   .oct_k     (oct_k),
   .ilas_done (ilas_done)
);

// File: tb/ilas_gen_test.sv
module ilas_gen_test;
   localparam int FW = 8;
   localparam int KW = 5;
   localparam int CFG_N = 14;
   localparam int NCASE = 4;
   // each entry: {f_m1, k_m1, sysref cycle (FFFF = none), sync release cycle}
   localparam logic [63:0] CASES [NCASE] = '{
      {16'd3, 16'd4,  16'hFFFF, 16'd7},
      {16'd0, 16'd16, 16'hFFFF, 16'd16},
      {16'd1, 16'd15, 16'd5,    16'd10},
      {16'd7, 16'd3,  16'hFFFF, 16'd0}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               sysref = 1'b0;
   logic               sync_n = 1'b0;
   logic [FW-1:0]      f_m1 = '0;
   logic [KW-1:0]      k_m1 = '0;
   logic [CFG_N*8-1:0] cfg_oct = '0;
   logic [7:0]         oct_data;
   logic               oct_k;
   logic               ilas_done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   ilas_gen #(.FW(FW), .KW(KW), .CFG_N(CFG_N)) uut (
      .clk(clk), .rst_n(rst_n), .sysref(sysref), .sync_n(sync_n),
      .f_m1(f_m1), .k_m1(k_m1), .cfg_oct(cfg_oct),
      .oct_data(oct_data), .oct_k(oct_k), .ilas_done(ilas_done)
   );

   task automatic check(string tag, int n, logic [7:0] ed, logic ek, logic edone);
      checks++;
      if (oct_data !== ed || oct_k !== ek || ilas_done !== edone) begin
         errors++;
         $display("FAIL %s cycle %0d: got data=%02h k=%0b done=%0b expected data=%02h k=%0b done=%0b",
                  tag, n, oct_data, oct_k, ilas_done, ed, ek, edone);
      end
   endtask

   function automatic int cnt_at(int t, int len, int s);
      if (s >= 0 && t > s) return (t - s - 1) % len;
      return t % len;
   endfunction

   task automatic do_reset(int fm, int km, int seed);
      rst_n  = 1'b0;
      sysref = 1'b0;
      sync_n = 1'b0;
      f_m1   = FW'(fm);
      k_m1   = KW'(km);
      for (int i = 0; i < CFG_N; i++) cfg_oct[8*i +: 8] = 8'(i * 17 + seed * 3 + 5);
      @(negedge clk);
      @(negedge clk);
      check("R3", -1, 8'hBC, 1'b1, 1'b0);  // reset state
      rst_n = 1'b1;
   endtask

   // expected octet of a sequence at offset u, for multiframe length len
   task automatic expect_seq(int u, int len, output logic [7:0] d, output logic k,
                             output string tag);
      int mf = u / len;
      int p  = u % len;
      k   = 1'b0;
      tag = (mf == 1) ? "R6" : "R5";
      if (p == 0) begin d = 8'h1C; k = 1'b1; end
      else if (p == len - 1) begin d = 8'h7C; k = 1'b1; end
      else if (mf == 1 && p == 1) begin d = 8'h9C; k = 1'b1; end
      else if (mf == 1 && p >= 2 && p <= 15) d = cfg_oct[8*(p-2) +: 8];
      else d = 8'(p);
   endtask

   initial begin
      for (int c = 0; c < NCASE; c++) begin
         int fm  = int'(CASES[c][63:48]);
         int km  = int'(CASES[c][47:32]);
         int s   = (CASES[c][31:16] == 16'hFFFF) ? -1 : int'(CASES[c][31:16]);
         int r   = int'(CASES[c][15:0]);
         int len = (fm + 1) * (km + 1);
         int t0  = r + 1;
         while (cnt_at(t0, len, s) != 0) t0++;
         do_reset(fm, km, c);
         for (int n = 0; n < t0 + 4 * len + 6; n++) begin
            logic [7:0] ed;
            logic       ek;
            string      tag;
            if (n < t0) begin
               ed = 8'hBC; ek = 1'b1; tag = "R3";
            end else if (n >= t0 + 4 * len) begin
               ed = 8'h00; ek = 1'b0; tag = "R4";
            end else begin
               expect_seq(n - t0, len, ed, ek, tag);
               if (n == t0 + 4 * len - 1) tag = "R7";
            end
            check(tag, n, ed, ek, (n == t0 + 4 * len - 1));
            if (n == t0) check((s >= 0) ? "R2" : "R1", n, 8'h1C, 1'b1, 1'b0);
            sysref = (n == s);
            sync_n = (n >= r);
            @(negedge clk);
         end
      end

      // directed: SYNC~ drops inside the sequence and inside the data phase
      do_reset(3, 4, 7);
      for (int n = 0; n < 130; n++) begin
         if (n == 31)  check("R8", n, 8'hBC, 1'b1, 1'b0);
         if (n == 39)  check("R8", n, 8'hBC, 1'b1, 1'b0);
         if (n == 40)  check("R8", n, 8'h1C, 1'b1, 1'b0);
         if (n == 41)  check("R5", n, 8'h01, 1'b0, 1'b0);
         if (n == 59)  check("R5", n, 8'h7C, 1'b1, 1'b0);
         if (n == 119) check("R7", n, 8'h7C, 1'b1, 1'b1);
         if (n == 120) check("R4", n, 8'h00, 1'b0, 1'b0);
         if (n == 126) check("R8", n, 8'hBC, 1'b1, 1'b0);
         sync_n = !((n >= 30 && n < 33) || n >= 125);
         @(negedge clk);
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int w = 0; w < 20000; w++) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule